// File: doc/BRIEF.md
# Windowed Overlapping Register File

This block is a register file for a processor core in which each procedure sees its own set of registers. A small group of global registers is shared by every procedure. The rest of the storage is arranged as a ring of windows, and a window pointer selects the current window. Each window is seen through three groups: inputs, locals and outputs. The outputs of one window occupy the same physical registers as the inputs of the next window in the ring.

A save strobe, issued on a call, moves the pointer to the next window. The values the caller placed in its outputs then appear in the callee's inputs, and nothing is copied. A restore strobe, issued on a return, moves the pointer back. A count of resident windows is kept. A save is refused and flagged when every window is in use. A restore is refused and flagged when only one window is resident. The block has two combinational read ports and one write port. Each port takes a 5-bit architectural index.

Top module: `win_regfile`

## Requirements
- R1: After a synchronous reset, exactly one window is resident. A restore in that state raises `underflow_o`.
- R2: Index 0 always reads as zero, and writes to it are dropped. Indices 0–7 are globals and map to the same storage in every window.
- R3: Indices 16–23 are locals, private to a window. A value the caller holds in a local survives a save, callee writes to the same index, and a restore.
- R4: Indices 8–15 are outputs and 24–31 are inputs. After a save, the callee's input k reads what the caller wrote to output k.
- R5: After a restore, the caller's output k reads what the callee wrote to its input k.
- R6: A save while `NWIN` windows are resident raises `overflow_o` in the same cycle and does not move the pointer. With `NWIN`=8, the first 7 saves after reset succeed and the 8th overflows.
- R7: A restore while one window is resident raises `underflow_o` in the same cycle and does not move the pointer.
- R8: A read of the index being written in the same cycle returns the new write data.
- R9: Reads and writes in a cycle that also carries a save or restore use the window pointer in effect before that cycle's move.
- R10: `overflow_o` is only raised together with `save_i`, and `underflow_o` only together with `restore_i`. When both strobes are high, the save takes effect and the restore is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ra_i | input | 5 | Read port A index |
| rd_a_o | output | DW | Read port A data |
| rb_i | input | 5 | Read port B index |
| rd_b_o | output | DW | Read port B data |
| we_i | input | 1 | Write enable |
| wa_i | input | 5 | Write index |
| wd_i | input | DW | Write data |
| save_i | input | 1 | Call strobe, advances the window |
| restore_i | input | 1 | Return strobe, moves the window back |
| overflow_o | output | 1 | Save refused, all windows resident |
| underflow_o | output | 1 | Restore refused, one window resident |

## Verification
The checker assumes that a strobe is held for exactly one clock cycle. It also assumes that an overflowed save or underflowed restore is not retried in the hope of a different result until software would have spilled or filled a window. The bench raises every strobe for a single cycle. It never asserts save and restore together except in the one case it deliberately tests. Before every save, the bench accounts for how many windows are resident, so each overflow and underflow it expects lands on a known cycle.

// File: rtl/win_regfile.sv
module win_regfile #(
  parameter int DW   = 32,
  parameter int NWIN = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [4:0]    ra_i,
  output logic [DW-1:0] rd_a_o,
  input  logic [4:0]    rb_i,
  output logic [DW-1:0] rd_b_o,
  input  logic          we_i,
  input  logic [4:0]    wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic          save_i,
  input  logic          restore_i,
  output logic          overflow_o,
  output logic          underflow_o
);
  localparam int NPHYS = 8 + 16 * NWIN;
  localparam int PW    = $clog2(NPHYS);
  localparam int WPW   = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam int CW    = $clog2(NWIN + 1);

  logic [DW-1:0]  regs [NPHYS];
  logic [WPW-1:0] cwp;
  logic [CW-1:0]  resident;

  function automatic logic [PW-1:0] phys(input logic [4:0] a, input logic [WPW-1:0] w);
    int base, nxt;
    base = 8 + 16 * int'(w);
    nxt  = (int'(w) == NWIN - 1) ? 8 : base + 16;
    case (a[4:3])
      2'd0:    return PW'(int'(a[2:0]));
      2'd1:    return PW'(nxt + int'(a[2:0]));
      2'd2:    return PW'(base + 8 + int'(a[2:0]));
      default: return PW'(base + int'(a[2:0]));
    endcase
  endfunction

  function automatic logic [DW-1:0] rd(input logic [4:0] a);
    if (a == 5'd0)                     return '0;
    else if (we_i && wa_i == a)        return wd_i;
    else                               return regs[phys(a, cwp)];
  endfunction

  assign rd_a_o = rd(ra_i);
  assign rd_b_o = rd(rb_i);

  wire do_save    = save_i;
  wire do_restore = restore_i && !save_i;

  assign overflow_o  = do_save && (resident == CW'(NWIN));
  assign underflow_o = do_restore && (resident == CW'(1));

  always_ff @(posedge clk)
    if (we_i && wa_i != 5'd0)
      regs[phys(wa_i, cwp)] <= wd_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp      <= '0;
      resident <= CW'(1);
    end else if (do_save && !overflow_o) begin
      cwp      <= (int'(cwp) == NWIN - 1) ? '0 : cwp + 1'b1;
      resident <= resident + 1'b1;
    end else if (do_restore && !underflow_o) begin
      cwp      <= (cwp == '0) ? WPW'(NWIN - 1) : cwp - 1'b1;
      resident <= resident - 1'b1;
    end
  end
endmodule

module win_regfile_chk #(
  parameter int NWIN = 8,
  parameter int WPW  = 3,
  parameter int CW   = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           save_i,
  input logic           restore_i,
  input logic           overflow_o,
  input logic           underflow_o,
  input logic [4:0]     ra_i,
  input logic           rd_a_zero,
  input logic [WPW-1:0] cwp,
  input logic [CW-1:0]  resident
);
  // R10
  ovf_needs_save_chk: assert property (@(posedge clk) disable iff (rst) overflow_o |-> save_i);
  // R10
  unf_needs_restore_chk: assert property (@(posedge clk) disable iff (rst) underflow_o |-> (restore_i && !save_i));
  // R6
  ovf_holds_ptr_chk: assert property (@(posedge clk) disable iff (rst) overflow_o |=> $stable(cwp) && $stable(resident));
  // R7
  unf_holds_ptr_chk: assert property (@(posedge clk) disable iff (rst) underflow_o |=> $stable(cwp) && $stable(resident));
  // R2
  g0_zero_chk: assert property (@(posedge clk) disable iff (rst) (ra_i == 5'd0) |-> rd_a_zero);
  // R1
  resident_range_chk: assert property (@(posedge clk) disable iff (rst) (resident >= CW'(1)) && (resident <= CW'(NWIN)));
  // R6
  save_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (save_i && !overflow_o) |=> resident == $past(resident) + 1'b1);
endmodule

bind win_regfile win_regfile_chk #(.NWIN(NWIN), .WPW(WPW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .save_i(save_i), .restore_i(restore_i),
  .overflow_o(overflow_o), .underflow_o(underflow_o), .ra_i(ra_i),
  .rd_a_zero(rd_a_o == '0), .cwp(cwp), .resident(resident));

// File: tb/sim_win_regfile.sv
`timescale 1ns/1ps
module sim_win_regfile;
  localparam int DW = 32;
  localparam int NWIN = 8;

  logic clk = 0, rst = 1;
  logic [4:0] ra_i = 0, rb_i = 0, wa_i = 0;
  logic [DW-1:0] wd_i = 0, rd_a_o, rd_b_o;
  logic we_i = 0, save_i = 0, restore_i = 0, overflow_o, underflow_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  win_regfile #(.DW(DW), .NWIN(NWIN)) u0 (.*);

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [DW-1:0] d);
    @(negedge clk); we_i = 1; wa_i = a; wd_i = d;
    @(negedge clk); we_i = 0;
  endtask

  task automatic rdA(input logic [4:0] a, output logic [DW-1:0] d);
    ra_i = a; #1; d = rd_a_o;
  endtask

  task automatic strobe(input bit s, input bit r, output bit ov, output bit un);
    @(negedge clk); save_i = s; restore_i = r; #1; ov = overflow_o; un = underflow_o;
    @(negedge clk); save_i = 0; restore_i = 0;
  endtask

  task automatic do_reset;
    rst = 1; repeat (3) @(negedge clk); rst = 0;
  endtask

  task automatic t_reset;
    logic [DW-1:0] d; bit ov, un;
    do_reset();
    rdA(0, d); chk("R2 g0 after reset", d, 0);
    strobe(0, 1, ov, un); chk("R1 underflow at reset", un, 1);
    chk("R10 no overflow on restore", ov, 0);
  endtask

  task automatic t_globals;
    logic [DW-1:0] d; bit ov, un;
    wr(0, 32'hdead_beef); rdA(0, d); chk("R2 g0 write dropped", d, 0);
    wr(3, 32'h1234_5678);
    strobe(1, 0, ov, un);
    rdA(3, d); chk("R2 global seen in callee", d, 32'h1234_5678);
    strobe(0, 1, ov, un);
  endtask

  task automatic t_args;
    logic [DW-1:0] d; bit ov, un;
    for (int k = 0; k < 4; k++) wr(5'(8 + k), 32'ha000_0000 + k);
    wr(16, 32'h5555_0001);
    strobe(1, 0, ov, un); chk("R6 save ok no overflow", ov, 0);
    for (int k = 0; k < 4; k++) begin
      rdA(5'(24 + k), d); chk("R4 arg in input", d, 32'ha000_0000 + k);
    end
    wr(16, 32'h6666_0002);
    wr(24, 32'hbbbb_0000);
    strobe(0, 1, ov, un); chk("R7 restore ok no underflow", un, 0);
    rdA(16, d); chk("R3 caller local kept", d, 32'h5555_0001);
    rdA(8, d);  chk("R5 callee input back in caller output", d, 32'hbbbb_0000);
  endtask

  task automatic t_overflow;
    logic [DW-1:0] d; bit ov, un;
    for (int k = 1; k < NWIN; k++) begin
      strobe(1, 0, ov, un); chk("R6 save below limit", ov, 0);
    end
    wr(17, 32'h7777_0007);
    strobe(1, 0, ov, un); chk("R6 overflow at limit", ov, 1);
    rdA(17, d); chk("R6 pointer held after overflow", d, 32'h7777_0007);
    for (int k = 1; k < NWIN; k++) begin
      strobe(0, 1, ov, un); chk("R7 restore above floor", un, 0);
    end
    wr(18, 32'h8888_0008);
    strobe(0, 1, ov, un); chk("R7 underflow at floor", un, 1);
    rdA(18, d); chk("R7 pointer held after underflow", d, 32'h8888_0008);
  endtask

  task automatic t_bypass;
    logic [DW-1:0] d;
    @(negedge clk); we_i = 1; wa_i = 5; wd_i = 32'hcafe_0005; rb_i = 5; ra_i = 5; #1;
    chk("R8 bypass port A", rd_a_o, 32'hcafe_0005);
    chk("R8 bypass port B", rd_b_o, 32'hcafe_0005);
    @(negedge clk); we_i = 0;
    rdA(5, d); chk("R8 value stored", d, 32'hcafe_0005);
  endtask

  task automatic t_sameCycle;
    logic [DW-1:0] d; bit ov, un;
    wr(9, 32'h1111_0009);
    @(negedge clk); save_i = 1; we_i = 1; wa_i = 8; wd_i = 32'h2222_0008; ra_i = 9; #1;
    chk("R9 read uses old window", rd_a_o, 32'h1111_0009);
    @(negedge clk); save_i = 0; we_i = 0;
    rdA(24, d); chk("R9 write used old window", d, 32'h2222_0008);
    rdA(25, d); chk("R9 save took effect", d, 32'h1111_0009);
    strobe(0, 1, ov, un);
    wr(10, 32'h3333_000a);
    strobe(1, 1, ov, un); chk("R10 save wins no underflow", un, 0);
    rdA(26, d); chk("R10 save wins over restore", d, 32'h3333_000a);
    strobe(0, 1, ov, un);
  endtask

  initial begin
    t_reset();
    t_globals();
    t_args();
    t_overflow();
    t_bypass();
    t_sameCycle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule